// File: doc/BRIEF.md
# Serial Scan Signature Compactor

This block is a 16-bit linear feedback register that sits next to a serial test path. It is driven by the test clock, and it works in one of three modes.

- **Compaction:** the register watches each bit travelling along the path during the data-shift phase and folds that bit into a running signature. The path itself is left untouched.
- **Access:** the feedback is turned off, and the register becomes an ordinary 16-bit serial shift stage inside the chain. A seed can be shifted in this way, or the signature can be shifted out.
- **Idle:** the register holds its contents.

A controller outside the block decides which mode applies and writes that choice through a small mode-write port. The same controller asserts the shift strobe while the path is in its data-shift phase. The block only ever changes its contents on a rising clock edge where that strobe is high.

Top module: `sig_compactor`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears the 16-bit register to zero and selects idle mode.
- R2: A rising edge with `mode_wr` high loads the mode from `mode_code`. Code 0 selects idle, 1 selects compaction, 2 selects access, and 3 is treated as idle. The new mode applies from the next edge.
- R3: In compaction mode, each edge with `shift_en` high sets fb = reg[0] XOR `path_in`. It then loads reg with (reg >> 1) XOR (fb ? 16'h8408 : 0). This is the polynomial x^16+x^12+x^5+1 in right-shifting form, so bit 15 becomes fb.
- R4: In compaction mode and in idle mode, `chain_out` equals `path_in` in the same cycle. The register is not in the path.
- R5: In access mode, `chain_out` is reg[0`]`. Each edge with `shift_en` high loads reg with {`path_in`, reg[15:1]}, with no feedback. Shifting in 16 bits LSB first therefore loads a seed.
- R6: In idle mode the register does not change, whatever `shift_en` and `path_in` do.
- R7: When `shift_en` is low, the register does not change in any mode.
- R8: A signature built in compaction mode, starting from a loaded seed, is read out in access mode LSB first over 16 shifts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| mode_wr | input | 1 | Mode write strobe |
| mode_code | input | 2 | Mode code, used when `mode_wr` is high |
| shift_en | input | 1 | High during the data-shift phase |
| path_in | input | 1 | Serial data arriving on the scan path |
| chain_out | output | 1 | Serial output toward the rest of the path |

## Verification
The assertions assume that `shift_en`, `path_in` and the mode inputs are free of X and settle well before each rising edge. They also assume that a mode write and a shift are never requested in the same cycle. Under those assumptions, the register's next value depends only on the current mode and the one sampled serial bit.

The stimulus changes every input on the falling clock edge. It always issues a mode write as its own cycle, with `shift_en` low. Readback in access mode recirculates `chain_out` into `path_in`, so reading the register out leaves its contents as they were.

// File: rtl/sigc_pkg.sv
package sigc_pkg;
  typedef enum logic [1:0] {
    MD_IDLE    = 2'd0,
    MD_COMPACT = 2'd1,
    MD_ACCESS  = 2'd2
  } sigc_mode_e;

  function automatic sigc_mode_e decode_mode(input logic [1:0] code);
    case (code)
      2'd1:    return MD_COMPACT;
      2'd2:    return MD_ACCESS;
      default: return MD_IDLE;
    endcase
  endfunction
endpackage

// File: rtl/sigc_mode_reg.sv
module sigc_mode_reg
  import sigc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr,
  input  logic [1:0] code,
  output sigc_mode_e mode
);
  always_ff @(posedge clk) begin
    if (rst)     mode <= MD_IDLE;
    else if (wr) mode <= decode_mode(code);
  end
endmodule

// File: rtl/sigc_next.sv
module sigc_next
  import sigc_pkg::*;
#(
  parameter int              W    = 16,
  parameter logic [W-1:0]    POLY = 16'h8408
) (
  input  logic [W-1:0] cur,
  input  logic         din,
  input  sigc_mode_e   mode,
  output logic [W-1:0] nxt
);
  logic         fb;
  logic [W-1:0] comp_v;
  logic [W-1:0] acc_v;

  assign fb = cur[0] ^ din;

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_bit
      if (i == W-1) begin : g_top
        assign comp_v[i] = fb & POLY[i];
        assign acc_v[i]  = din;
      end else begin : g_low
        assign comp_v[i] = cur[i+1] ^ (fb & POLY[i]);
        assign acc_v[i]  = cur[i+1];
      end
    end
  endgenerate

  always_comb begin
    case (mode)
      MD_COMPACT: nxt = comp_v;
      MD_ACCESS:  nxt = acc_v;
      default:    nxt = cur;
    endcase
  end
endmodule

// File: rtl/sigc_state_reg.sv
module sigc_state_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (en) q <= d;
  end
endmodule

// File: rtl/sig_compactor.sv
module sig_compactor
  import sigc_pkg::*;
#(
  parameter int           W    = 16,
  parameter logic [W-1:0] POLY = 16'h8408
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       mode_wr,
  input  logic [1:0] mode_code,
  input  logic       shift_en,
  input  logic       path_in,
  output logic       chain_out
);
  sigc_mode_e   mode_q;
  logic [W-1:0] sig_q;
  logic [W-1:0] sig_d;

  sigc_mode_reg u_mode (
    .clk  (clk),
    .rst  (rst),
    .wr   (mode_wr),
    .code (mode_code),
    .mode (mode_q)
  );

  sigc_next #(.W(W), .POLY(POLY)) u_next (
    .cur  (sig_q),
    .din  (path_in),
    .mode (mode_q),
    .nxt  (sig_d)
  );

  sigc_state_reg #(.W(W)) u_state (
    .clk (clk),
    .rst (rst),
    .en  (shift_en),
    .d   (sig_d),
    .q   (sig_q)
  );

  // Only access mode puts the register into the path
  assign chain_out = (mode_q == MD_ACCESS) ? sig_q[0] : path_in;
endmodule

// File: rtl/sigc_checker.sv
module sigc_checker #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic [1:0]   mode,
  input logic         shift_en,
  input logic         path_in,
  input logic         chain_out,
  input logic [W-1:0] sig
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) $past(rst) |-> (sig == '0 && mode == 2'd0));

  // R7
  no_shift_hold_chk: assert property (@(posedge clk) disable iff (rst) !shift_en |=> $stable(sig));

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst) (mode == 2'd0) |=> $stable(sig));

  // R3
  compact_fb_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd1 && shift_en) |=> sig[W-1] == ($past(sig[0]) ^ $past(path_in)));

  // R5
  access_shift_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd2 && shift_en) |=> (sig[W-1] == $past(path_in) && sig[W-2:0] == $past(sig[W-1:1])));

  // R4
  passthru_chk: assert property (@(posedge clk) disable iff (rst)
    (mode != 2'd2) |-> chain_out == path_in);
endmodule

bind sig_compactor sigc_checker #(.W(W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .mode      (mode_q),
  .shift_en  (shift_en),
  .path_in   (path_in),
  .chain_out (chain_out),
  .sig       (sig_q)
);

// File: tb/sim_sig_compactor.sv
`timescale 1ns/1ps
module sim_sig_compactor;
  logic clk = 0;
  logic rst = 1;
  logic mode_wr = 0;
  logic [1:0] mode_code = 0;
  logic shift_en = 0;
  logic path_in = 0;
  logic chain_out;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  logic [15:0] model;
  logic [15:0] rd;

  always #2 clk = ~clk;

  sig_compactor u0 (
    .clk(clk), .rst(rst), .mode_wr(mode_wr), .mode_code(mode_code),
    .shift_en(shift_en), .path_in(path_in), .chain_out(chain_out)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, got, exp);
    end
  endtask

  function automatic logic [15:0] comp(input logic [15:0] r, input logic d);
    logic fb;
    fb = r[0] ^ d;
    return (r >> 1) ^ (fb ? 16'h8408 : 16'h0000);
  endfunction

  task automatic set_mode(input logic [1:0] c);
    shift_en = 0; mode_wr = 1; mode_code = c;
    tick();
    mode_wr = 0;
  endtask

  // Read the register out in access mode while recirculating, then restore mode
  task automatic unload(input logic [1:0] back, output logic [15:0] v);
    set_mode(2'd2);
    for (int i = 0; i < 16; i++) begin
      v[i] = chain_out;
      path_in = chain_out;
      shift_en = 1;
      tick();
    end
    shift_en = 0;
    set_mode(back);
  endtask

  task automatic load_seed(input logic [15:0] seed);
    set_mode(2'd2);
    for (int i = 0; i < 16; i++) begin
      check("R5 chain_out is reg lsb", chain_out, model[0]);
      path_in = seed[i];
      shift_en = 1;
      tick();
      model = {seed[i], model[15:1]};
    end
    shift_en = 0;
  endtask

  task automatic t_reset();
    rst = 1; tick(); tick(); rst = 0;
    model = 0;
    path_in = 1; #0.5;
    check("R1 idle passthrough high", chain_out, 1);
    path_in = 0; #0.5;
    check("R1 idle passthrough low", chain_out, 0);
    unload(2'd0, rd);
    check("R1 register cleared", rd, 16'h0);
  endtask

  task automatic t_seed_and_compact(input logic [15:0] seed, input int kind);
    logic [15:0] g;
    load_seed(seed);
    check("R5 seed loaded", model, seed);
    unload(2'd1, rd);
    check("R5 seed readback", rd, seed);
    g = 16'hACE1;
    for (int i = 0; i < 48; i++) begin
      logic b;
      case (kind)
        0: b = 1'b1;
        1: b = i[0];
        default: begin b = g[0]; g = {g[0] ^ g[2] ^ g[3] ^ g[5], g[15:1]}; end
      endcase
      path_in = b; shift_en = 1; #0.5;
      if (i % 8 == 0) check("R4 compaction passthrough", chain_out, b);
      tick();
      model = comp(model, b);
    end
    shift_en = 0;
    unload(2'd0, rd);
    check("R3 R8 signature", rd, model);
  endtask

  task automatic t_mode_codes();
    set_mode(2'd3);
    for (int i = 0; i < 12; i++) begin
      path_in = i[1]; shift_en = 1; tick();
    end
    shift_en = 0;
    #0.5 check("R2 code 3 passthrough", chain_out, path_in);
    unload(2'd0, rd);
    check("R2 code 3 acts as idle", rd, model);
    set_mode(2'd2);
    check("R2 access applies next cycle", chain_out, model[0]);
    set_mode(2'd0);
  endtask

  task automatic t_idle_hold();
    set_mode(2'd0);
    for (int i = 0; i < 20; i++) begin
      path_in = ~i[0]; shift_en = 1; tick();
    end
    shift_en = 0;
    unload(2'd0, rd);
    check("R6 idle holds", rd, model);
  endtask

  task automatic t_shift_low();
    set_mode(2'd1);
    for (int i = 0; i < 10; i++) begin path_in = i[0]; tick(); end
    unload(2'd2, rd);
    check("R7 compaction no strobe", rd, model);
    for (int i = 0; i < 10; i++) begin
      path_in = ~i[0]; tick();
      check("R7 access no strobe", chain_out, model[0]);
    end
    set_mode(2'd0);
    unload(2'd0, rd);
    check("R7 access register unchanged", rd, model);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_seed_and_compact(16'hFFFF, 0);
    t_seed_and_compact(16'h1234, 1);
    t_seed_and_compact(16'h0000, 2);
    t_mode_codes();
    t_idle_hold();
    t_shift_low();
    t_reset();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule